// File: doc/BRIEF.md
# Real-Time Clock Calendar

This block keeps wall-clock time and a calendar from one sub-second timing pulse at 128 Hz. An internal 7-bit divider counts these pulses and derives the one-second step. The second step then carries through seconds, minutes, hours, day of month, month and a two-digit year. A day-of-week counter runs alongside the calendar. The counters hold binary values, and the hour is kept internally in 24-hour form.

The host sets time, date and an alarm through parallel load strobes. Each strobe is one clock cycle wide and its value ports are sampled in that cycle. Writing the time also clears the sub-second divider, so the next second starts a full period after the write. The hour can be shown in 12-hour form with a PM flag instead of 24-hour form. An alarm pulse is raised when a second step brings all six time and date fields to the programmed alarm values. A periodic tick pulse is raised at one of eight power-of-two fractions of a second.

Top module: `rtc_calendar`

## Requirements
- R1: While reset is asserted, and until the first strobe or tick after reset, the outputs read 00:00:00 in 24-hour form, day 1, month 1, year 0, weekday 0, and both pulse outputs are low.
- R2: Seconds advance by one on every 128th accepted `tick_128_i` pulse. The divider is cleared by a time write, so after a write exactly 127 further pulses leave the seconds unchanged and the 128th pulse advances them.
- R3: A second step past 59 wraps seconds to 0 and advances minutes. Minutes past 59 wrap to 0 and advance the hour. Hour 23 wraps to 0 and produces a day rollover.
- R4: A day rollover past the last day of the month sets the day to 1. Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year is a multiple of 4 (year 0 included) and 28 days otherwise. All other months have 31 days.
- R5: A rollover out of month 12 gives month 1 and increments the year, and year 99 wraps to 0.
- R6: The weekday counter (0 to 6) advances by one on every day rollover and wraps from 6 to 0.
- R7: With `mode_12h_i` low, `hour_o` shows the 24-hour value and `pm_o` is 0. With it high, hour 0 shows 12 with `pm_o` 0, hours 1 to 11 show unchanged with `pm_o` 0, hour 12 shows 12 with `pm_o` 1, and hours 13 to 23 show 1 to 11 with `pm_o` 1. The flag therefore toggles on the step from 11 to 12.
- R8: `alarm_irq_o` is high for exactly the one cycle in which the outputs first show, by a second step, a second, minute, hour (24-hour value), day, month and year all equal to the programmed alarm. Direct loads of time or date never raise it.
- R9: `tick_irq_o` pulses once for every 2^k accepted `tick_128_i` pulses, where k is `tick_sel_i` (0 gives 1/128 s and 7 gives 1 s). The pulse is raised when the divider reaches a multiple of 2^k, so with k = 7 it coincides with the second step.
- R10: `time_wr_i` loads seconds, minutes and hour (24-hour value) and overrides a tick in the same cycle. `date_wr_i` loads day, month, year and weekday and overrides a day rollover in the same cycle. `alm_wr_i` loads the six alarm fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_128_i | input | 1 | One-cycle pulse at 128 Hz |
| tick_sel_i | input | 3 | Periodic tick rate select, period 2^k/128 s |
| mode_12h_i | input | 1 | 1 selects 12-hour display |
| time_wr_i | input | 1 | Time load strobe |
| set_sec_i | input | 6 | Seconds to load (0-59) |
| set_min_i | input | 6 | Minutes to load (0-59) |
| set_hour_i | input | 5 | Hour to load, 24-hour value (0-23) |
| date_wr_i | input | 1 | Date load strobe |
| set_day_i | input | 5 | Day of month to load |
| set_mon_i | input | 4 | Month to load (1-12) |
| set_year_i | input | 7 | Year to load (0-99) |
| set_dow_i | input | 3 | Weekday to load (0-6) |
| alm_wr_i | input | 1 | Alarm load strobe |
| alm_sec_i | input | 6 | Alarm seconds |
| alm_min_i | input | 6 | Alarm minutes |
| alm_hour_i | input | 5 | Alarm hour, 24-hour value |
| alm_day_i | input | 5 | Alarm day of month |
| alm_mon_i | input | 4 | Alarm month |
| alm_year_i | input | 7 | Alarm year |
| sec_o | output | 6 | Current seconds |
| min_o | output | 6 | Current minutes |
| hour_o | output | 5 | Current hour in selected display form |
| pm_o | output | 1 | PM flag in 12-hour mode |
| day_o | output | 5 | Current day of month |
| mon_o | output | 4 | Current month |
| year_o | output | 7 | Current year |
| dow_o | output | 3 | Current weekday |
| alarm_irq_o | output | 1 | One-cycle alarm pulse |
| tick_irq_o | output | 1 | One-cycle periodic tick pulse |

## Verification
The range assertions assume that every loaded time and date is legal. Seconds and minutes must be below 60, the hour below 24, the month between 1 and 12, the year below 100, the weekday below 7, and the day must fit the loaded month and year. The bench builds every load value inside these limits and computes the day bound with its own month-length function. Random loads are placed near minute, hour, month, year and leap-day boundaries, so rollovers occur within a few simulated seconds. Tick density, rate select and display mode are varied between runs.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [5:0] SEC_LAST  = 6'd59;
  localparam logic [5:0] MIN_LAST  = 6'd59;
  localparam logic [4:0] HOUR_LAST = 5'd23;
  localparam logic [3:0] MON_LAST  = 4'd12;
  localparam logic [2:0] DOW_LAST  = 3'd6;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
  } rtc_time_t;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] day;
    logic [2:0] dow;
  } rtc_date_t;

  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
    logic [4:0] len;
    case (mon)
      4'd2:                         len = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:      len = 5'd30;
      default:                      len = 5'd31;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
  parameter int TICK_W = 7,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             sec_adv_o,
  output logic             tick_irq_o
);

  logic [TICK_W-1:0] div_q, div_d, div_inc;
  logic              hit, irq_d;

  always_comb begin
    div_inc = div_q + 1'b1;
    hit     = 1'b1;
    for (int i = 0; i < TICK_W; i++) begin
      if (i < int'(sel_i)) hit = hit & ~div_inc[i];
    end
    sec_adv_o = tick_i & ~clr_i & (&div_q);
    irq_d     = tick_i & ~clr_i & hit;
    div_d     = div_q;
    if (clr_i)       div_d = '0;
    else if (tick_i) div_d = div_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q      <= '0;
      tick_irq_o <= 1'b0;
    end else begin
      div_q      <= div_d;
      tick_irq_o <= irq_d;
    end
  end

  // R9
  tick_sec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_adv_o && int'(sel_i) == TICK_W) |=> tick_irq_o);

  // R9
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !tick_irq_o);

  // R2
  div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (div_q == '0));

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv_i,
  input  logic      wr_i,
  input  rtc_time_t wr_val_i,
  output rtc_time_t time_o,
  output rtc_time_t time_nx_o,
  output logic      day_carry_o
);

  rtc_time_t time_q, time_d;
  logic      carry;

  always_comb begin
    time_d = time_q;
    carry  = 1'b0;
    if (wr_i) begin
      time_d = wr_val_i;
    end else if (adv_i) begin
      if (time_q.sec == SEC_LAST) begin
        time_d.sec = '0;
        if (time_q.min == MIN_LAST) begin
          time_d.min = '0;
          if (time_q.hour == HOUR_LAST) begin
            time_d.hour = '0;
            carry       = 1'b1;
          end else begin
            time_d.hour = time_q.hour + 5'd1;
          end
        end else begin
          time_d.min = time_q.min + 6'd1;
        end
      end else begin
        time_d.sec = time_q.sec + 6'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_d;
  end

  assign time_o      = time_q;
  assign time_nx_o   = time_d;
  assign day_carry_o = carry;

  // R3
  time_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q.sec <= SEC_LAST && time_q.min <= MIN_LAST && time_q.hour <= HOUR_LAST));

  // R3
  min_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_i && time_q.sec == SEC_LAST) |=>
      (time_q.sec == '0 && time_q.min != $past(time_q.min)));

  // R10
  time_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (time_q == $past(wr_val_i)));

endmodule

// File: rtl/rtc_datekeeper.sv
module rtc_datekeeper
  import rtc_pkg::*;
#(
  parameter int YEAR_LAST = 99
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      carry_i,
  input  logic      wr_i,
  input  rtc_date_t wr_val_i,
  output rtc_date_t date_o,
  output rtc_date_t date_nx_o
);

  localparam logic [6:0] YEAR_TOP = 7'(YEAR_LAST);

  rtc_date_t  date_q, date_d;
  logic       leap;
  logic [4:0] dim;

  always_comb begin
    leap   = (date_q.year[1:0] == 2'b00);
    dim    = month_len(date_q.mon, leap);
    date_d = date_q;
    if (wr_i) begin
      date_d = wr_val_i;
    end else if (carry_i) begin
      date_d.dow = (date_q.dow == DOW_LAST) ? 3'd0 : date_q.dow + 3'd1;
      if (date_q.day >= dim) begin
        date_d.day = 5'd1;
        if (date_q.mon == MON_LAST) begin
          date_d.mon  = 4'd1;
          date_d.year = (date_q.year == YEAR_TOP) ? 7'd0 : date_q.year + 7'd1;
        end else begin
          date_d.mon = date_q.mon + 4'd1;
        end
      end else begin
        date_d.day = date_q.day + 5'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      date_q.year <= 7'd0;
      date_q.mon  <= 4'd1;
      date_q.day  <= 5'd1;
      date_q.dow  <= 3'd0;
    end else begin
      date_q <= date_d;
    end
  end

  assign date_o    = date_q;
  assign date_nx_o = date_d;

  // R4
  day_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (date_q.day >= 5'd1 && date_q.day <= dim));

  // R4
  leap_feb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_i && !wr_i && date_q.mon == 4'd2 && date_q.day == 5'd28 && date_q.year[1:0] == 2'b00)
      |=> (date_q.day == 5'd29));

  // R5
  year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_i && !wr_i && date_q.mon == MON_LAST && date_q.day == 5'd31 && date_q.year == YEAR_TOP)
      |=> (date_q.year == 7'd0 && date_q.mon == 4'd1));

  // R6
  dow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_i && !wr_i) |=>
      (date_q.dow == (($past(date_q.dow) == DOW_LAST) ? 3'd0 : $past(date_q.dow) + 3'd1)));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  rtc_time_t  alm_time_i,
  input  logic [4:0] alm_day_i,
  input  logic [3:0] alm_mon_i,
  input  logic [6:0] alm_year_i,
  input  logic       adv_i,
  input  logic       block_i,
  input  rtc_time_t  nx_time_i,
  input  logic [4:0] nx_day_i,
  input  logic [3:0] nx_mon_i,
  input  logic [6:0] nx_year_i,
  input  rtc_time_t  cur_time_i,
  input  logic [4:0] cur_day_i,
  input  logic [3:0] cur_mon_i,
  input  logic [6:0] cur_year_i,
  output logic       irq_o
);

  rtc_time_t  a_time_q, a_time_d;
  logic [4:0] a_day_q, a_day_d;
  logic [3:0] a_mon_q, a_mon_d;
  logic [6:0] a_year_q, a_year_d;
  logic       match, irq_d;

  always_comb begin
    a_time_d = a_time_q;
    a_day_d  = a_day_q;
    a_mon_d  = a_mon_q;
    a_year_d = a_year_q;
    if (wr_i) begin
      a_time_d = alm_time_i;
      a_day_d  = alm_day_i;
      a_mon_d  = alm_mon_i;
      a_year_d = alm_year_i;
    end
    match = (nx_time_i == a_time_q) && (nx_day_i == a_day_q) &&
            (nx_mon_i == a_mon_q) && (nx_year_i == a_year_q);
    irq_d = adv_i & ~block_i & match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_time_q <= '0;
      a_day_q  <= '0;
      a_mon_q  <= '0;
      a_year_q <= '0;
      irq_o    <= 1'b0;
    end else begin
      a_time_q <= a_time_d;
      a_day_q  <= a_day_d;
      a_mon_q  <= a_mon_d;
      a_year_q <= a_year_d;
      irq_o    <= irq_d;
    end
  end

  // R8
  alarm_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cur_time_i == $past(a_time_q) && cur_day_i == $past(a_day_q) &&
               cur_mon_i == $past(a_mon_q) && cur_year_i == $past(a_year_q)));

  // R8
  alarm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(adv_i));

  // R8
  alarm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

endmodule

// File: rtl/rtc_hour_fmt.sv
module rtc_hour_fmt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode12_i,
  input  logic [4:0] hour24_i,
  output logic [4:0] hour_o,
  output logic       pm_o
);

  always_comb begin
    hour_o = hour24_i;
    pm_o   = 1'b0;
    if (mode12_i) begin
      pm_o = (hour24_i >= 5'd12);
      if (hour24_i == 5'd0)      hour_o = 5'd12;
      else if (hour24_i > 5'd12) hour_o = hour24_i - 5'd12;
    end
  end

  // R7
  twelve_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode12_i |-> (hour_o >= 5'd1 && hour_o <= 5'd12));

  // R7
  pm_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode12_i && $past(mode12_i) && $past(hour24_i) == 5'd11 && hour24_i == 5'd12)
      |-> (pm_o && !$past(pm_o)));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int TICK_W    = 7,
  parameter int YEAR_LAST = 99,
  localparam int SEL_W    = $clog2(TICK_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_128_i,
  input  logic [SEL_W-1:0] tick_sel_i,
  input  logic             mode_12h_i,
  input  logic             time_wr_i,
  input  logic [5:0]       set_sec_i,
  input  logic [5:0]       set_min_i,
  input  logic [4:0]       set_hour_i,
  input  logic             date_wr_i,
  input  logic [4:0]       set_day_i,
  input  logic [3:0]       set_mon_i,
  input  logic [6:0]       set_year_i,
  input  logic [2:0]       set_dow_i,
  input  logic             alm_wr_i,
  input  logic [5:0]       alm_sec_i,
  input  logic [5:0]       alm_min_i,
  input  logic [4:0]       alm_hour_i,
  input  logic [4:0]       alm_day_i,
  input  logic [3:0]       alm_mon_i,
  input  logic [6:0]       alm_year_i,
  output logic [5:0]       sec_o,
  output logic [5:0]       min_o,
  output logic [4:0]       hour_o,
  output logic             pm_o,
  output logic [4:0]       day_o,
  output logic [3:0]       mon_o,
  output logic [6:0]       year_o,
  output logic [2:0]       dow_o,
  output logic             alarm_irq_o,
  output logic             tick_irq_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  rtc_time_t wr_time, alm_time, cur_time, nx_time;
  rtc_date_t wr_date, cur_date, nx_date;
  logic      sec_adv, day_carry;

  assign wr_time  = '{sec: set_sec_i, min: set_min_i, hour: set_hour_i};
  assign alm_time = '{sec: alm_sec_i, min: alm_min_i, hour: alm_hour_i};
  assign wr_date  = '{year: set_year_i, mon: set_mon_i, day: set_day_i, dow: set_dow_i};

  rtc_subsec #(.TICK_W(TICK_W), .SEL_W(SEL_W)) subsec_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .tick_i     (tick_128_i),
    .clr_i      (time_wr_i),
    .sel_i      (tick_sel_i),
    .sec_adv_o  (sec_adv),
    .tick_irq_o (tick_irq_o)
  );

  rtc_timekeeper time_i (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .adv_i       (sec_adv),
    .wr_i        (time_wr_i),
    .wr_val_i    (wr_time),
    .time_o      (cur_time),
    .time_nx_o   (nx_time),
    .day_carry_o (day_carry)
  );

  rtc_datekeeper #(.YEAR_LAST(YEAR_LAST)) date_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .carry_i   (day_carry),
    .wr_i      (date_wr_i),
    .wr_val_i  (wr_date),
    .date_o    (cur_date),
    .date_nx_o (nx_date)
  );

  rtc_alarm alarm_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_i       (alm_wr_i),
    .alm_time_i (alm_time),
    .alm_day_i  (alm_day_i),
    .alm_mon_i  (alm_mon_i),
    .alm_year_i (alm_year_i),
    .adv_i      (sec_adv),
    .block_i    (date_wr_i),
    .nx_time_i  (nx_time),
    .nx_day_i   (nx_date.day),
    .nx_mon_i   (nx_date.mon),
    .nx_year_i  (nx_date.year),
    .cur_time_i (cur_time),
    .cur_day_i  (cur_date.day),
    .cur_mon_i  (cur_date.mon),
    .cur_year_i (cur_date.year),
    .irq_o      (alarm_irq_o)
  );

  rtc_hour_fmt fmt_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .mode12_i (mode_12h_i),
    .hour24_i (cur_time.hour),
    .hour_o   (hour_o),
    .pm_o     (pm_o)
  );

  assign sec_o  = cur_time.sec;
  assign min_o  = cur_time.min;
  assign day_o  = cur_date.day;
  assign mon_o  = cur_date.mon;
  assign year_o = cur_date.year;
  assign dow_o  = cur_date.dow;

endmodule

// File: tb/rtc_calendar_tb_top.sv
module rtc_calendar_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct packed {
    int sec; int min; int hour; int day; int mon; int year; int dow;
  } cal_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_128_i = 1'b0;
  logic [2:0] tick_sel_i = 3'd0;
  logic mode_12h_i = 1'b0;
  logic time_wr_i = 1'b0, date_wr_i = 1'b0, alm_wr_i = 1'b0;
  logic [5:0] set_sec_i = '0, set_min_i = '0, alm_sec_i = '0, alm_min_i = '0;
  logic [4:0] set_hour_i = '0, set_day_i = '0, alm_hour_i = '0, alm_day_i = '0;
  logic [3:0] set_mon_i = '0, alm_mon_i = '0;
  logic [6:0] set_year_i = '0, alm_year_i = '0;
  logic [2:0] set_dow_i = '0;
  logic [5:0] sec_o, min_o;
  logic [4:0] hour_o, day_o;
  logic       pm_o, alarm_irq_o, tick_irq_o;
  logic [3:0] mon_o;
  logic [6:0] year_o;
  logic [2:0] dow_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  cal_t m, m_alm;
  int   m_div;
  bit   e_tick, e_alarm;

  always #4 clk = ~clk;

  rtc_calendar dut_i (
    .clk(clk), .rst_n(rst_n), .tick_128_i(tick_128_i), .tick_sel_i(tick_sel_i),
    .mode_12h_i(mode_12h_i), .time_wr_i(time_wr_i), .set_sec_i(set_sec_i),
    .set_min_i(set_min_i), .set_hour_i(set_hour_i), .date_wr_i(date_wr_i),
    .set_day_i(set_day_i), .set_mon_i(set_mon_i), .set_year_i(set_year_i),
    .set_dow_i(set_dow_i), .alm_wr_i(alm_wr_i), .alm_sec_i(alm_sec_i),
    .alm_min_i(alm_min_i), .alm_hour_i(alm_hour_i), .alm_day_i(alm_day_i),
    .alm_mon_i(alm_mon_i), .alm_year_i(alm_year_i), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .pm_o(pm_o), .day_o(day_o), .mon_o(mon_o), .year_o(year_o),
    .dow_o(dow_o), .alarm_irq_o(alarm_irq_o), .tick_irq_o(tick_irq_o)
  );

  function automatic int dim(int mon, int year);
    if (mon == 2) return (year % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic cal_t bump(cal_t c);
    cal_t n = c;
    n.sec = c.sec + 1;
    if (n.sec == 60) begin
      n.sec = 0; n.min = c.min + 1;
      if (n.min == 60) begin
        n.min = 0; n.hour = c.hour + 1;
        if (n.hour == 24) begin
          n.hour = 0;
          n.dow  = (c.dow + 1) % 7;
          n.day  = c.day + 1;
          if (c.day >= dim(c.mon, c.year)) begin
            n.day = 1; n.mon = c.mon + 1;
            if (c.mon == 12) begin
              n.mon = 1; n.year = (c.year + 1) % 100;
            end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic int disp_hour(int h, bit m12);
    if (!m12) return h;
    if (h == 0) return 12;
    if (h > 12) return h - 12;
    return h;
  endfunction

  task automatic chk(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(int'(sec_o), m.sec, "R3 seconds");
    chk(int'(min_o), m.min, "R3 minutes");
    chk(int'(hour_o), disp_hour(m.hour, mode_12h_i), "R7 hour display");
    chk(int'(pm_o), (mode_12h_i && m.hour >= 12) ? 1 : 0, "R7 pm flag");
    chk(int'(day_o), m.day, "R4 day");
    chk(int'(mon_o), m.mon, "R5 month");
    chk(int'(year_o), m.year, "R5 year");
    chk(int'(dow_o), m.dow, "R6 weekday");
    chk(int'(alarm_irq_o), int'(e_alarm), "R8 alarm pulse");
    chk(int'(tick_irq_o), int'(e_tick), "R9 tick pulse");
  endtask

  // One clock: drive at negedge, update model after posedge, compare.
  task automatic step(bit tk, bit twr, bit dwr, bit awr, cal_t wv, cal_t av);
    cal_t nc;
    bit   adv;
    int   nd;
    @(negedge clk);
    tick_128_i = tk; time_wr_i = twr; date_wr_i = dwr; alm_wr_i = awr;
    set_sec_i = 6'(wv.sec); set_min_i = 6'(wv.min); set_hour_i = 5'(wv.hour);
    set_day_i = 5'(wv.day); set_mon_i = 4'(wv.mon); set_year_i = 7'(wv.year);
    set_dow_i = 3'(wv.dow);
    alm_sec_i = 6'(av.sec); alm_min_i = 6'(av.min); alm_hour_i = 5'(av.hour);
    alm_day_i = 5'(av.day); alm_mon_i = 4'(av.mon); alm_year_i = 7'(av.year);
    @(posedge clk);
    #1;
    nc = m; adv = 1'b0; e_tick = 1'b0; e_alarm = 1'b0;
    if (twr) begin
      nc.sec = wv.sec; nc.min = wv.min; nc.hour = wv.hour; m_div = 0;
    end else if (tk) begin
      nd     = (m_div + 1) % 128;
      e_tick = ((nd % (1 << tick_sel_i)) == 0);
      adv    = (m_div == 127);
      m_div  = nd;
      if (adv) nc = bump(m);
    end
    if (dwr) begin
      nc.day = wv.day; nc.mon = wv.mon; nc.year = wv.year; nc.dow = wv.dow;
    end
    if (adv && !dwr && nc.sec == m_alm.sec && nc.min == m_alm.min &&
        nc.hour == m_alm.hour && nc.day == m_alm.day && nc.mon == m_alm.mon &&
        nc.year == m_alm.year) e_alarm = 1'b1;
    if (awr) m_alm = av;
    m = nc;
    compare_all();
  endtask

  task automatic run_case(cal_t st, int k, int secs, int pct, int sel, bit m12);
    cal_t a = st;
    cal_t z = '0;
    int   ticks = 0;
    for (int i = 0; i < k; i++) a = bump(a);
    @(negedge clk);
    tick_sel_i = 3'(sel);
    mode_12h_i = m12;
    step(1'b0, 1'b1, 1'b1, 1'b1, st, a);
    while (ticks < secs * 128) begin
      bit tk = ($urandom_range(99, 0) < pct);
      if (tk) ticks++;
      step(tk, 1'b0, 1'b0, 1'b0, z, z);
    end
  endtask

  function automatic cal_t mk(int h, int mi, int s, int d, int mo, int y, int w);
    cal_t c;
    c.hour = h; c.min = mi; c.sec = s; c.day = d; c.mon = mo; c.year = y; c.dow = w;
    return c;
  endfunction

  initial begin
    cal_t z = '0;
    cal_t w;
    void'($urandom(32'd20240611));
    m = mk(0, 0, 0, 1, 1, 0, 0);
    m_alm = '0;
    m_div = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while reset is held
    chk(int'(sec_o), 0, "R1 reset seconds");
    chk(int'(hour_o), 0, "R1 reset hour");
    chk(int'(day_o), 1, "R1 reset day");
    chk(int'(mon_o), 1, "R1 reset month");
    chk(int'(year_o), 0, "R1 reset year");
    chk(int'(dow_o), 0, "R1 reset weekday");
    chk(int'(alarm_irq_o) + int'(tick_irq_o), 0, "R1 reset pulses");
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 1'b0, 1'b0, z, z);

    // R10: time write overrides a same-cycle tick
    tick_sel_i = 3'd7;
    w = mk(10, 20, 30, 15, 6, 24, 3);
    step(1'b1, 1'b1, 1'b1, 1'b0, w, z);
    chk(int'(sec_o), 30, "R10 time load sec");
    chk(int'(hour_o), 10, "R10 time load hour");
    chk(int'(day_o), 15, "R10 date load day");
    chk(int'(dow_o), 3, "R10 date load weekday");
    // R2: 127 ticks hold, 128th advances
    repeat (127) step(1'b1, 1'b0, 1'b0, 1'b0, z, z);
    chk(int'(sec_o), 30, "R2 no step before 128 ticks");
    step(1'b1, 1'b0, 1'b0, 1'b0, z, z);
    chk(int'(sec_o), 31, "R2 step on 128th tick");
    chk(int'(tick_irq_o), 1, "R9 one-second tick aligned");

    // Directed corners
    run_case(mk(23, 59, 58, 28, 2, 4, 6), 2, 4, 100, 0, 1'b0);  // R4 leap
    chk(int'(day_o), 29, "R4 leap February");
    run_case(mk(23, 59, 58, 28, 2, 5, 6), 2, 4, 100, 3, 1'b1);  // R4 common year
    chk(int'(mon_o), 3, "R4 non-leap February end");
    run_case(mk(23, 59, 57, 31, 12, 99, 6), 3, 4, 90, 5, 1'b0); // R5 R6
    chk(int'(year_o), 0, "R5 year wraps");
    chk(int'(dow_o), 0, "R6 weekday wraps");
    run_case(mk(11, 59, 58, 30, 4, 7, 2), 2, 4, 100, 7, 1'b1);  // R7 noon
    chk(int'(pm_o), 1, "R7 pm after noon");
    run_case(mk(23, 59, 58, 30, 4, 7, 2), 9, 4, 100, 1, 1'b1);  // R7 midnight
    chk(int'(hour_o), 12, "R7 midnight shows 12");

    // Random cases near boundaries
    for (int n = 0; n < 30; n++) begin
      cal_t s;
      int   pick;
      pick   = $urandom_range(2, 0);
      s.mon  = (pick == 0) ? 2 : (pick == 1) ? 12 : $urandom_range(12, 1);
      pick   = $urandom_range(4, 0);
      s.year = (pick == 0) ? 99 : (pick == 1) ? 3 : (pick == 2) ? 4 : (pick == 3) ? 0 : $urandom_range(99, 0);
      pick   = $urandom_range(2, 0);
      s.day  = (pick == 0) ? dim(s.mon, s.year) : (pick == 1) ? dim(s.mon, s.year) - 1
                                               : $urandom_range(dim(s.mon, s.year), 1);
      pick   = $urandom_range(2, 0);
      s.hour = (pick == 0) ? 23 : (pick == 1) ? 11 : $urandom_range(23, 0);
      s.min  = $urandom_range(1, 0) ? 59 : $urandom_range(59, 0);
      s.sec  = $urandom_range(59, 50);
      s.dow  = $urandom_range(6, 0);
      run_case(s, $urandom_range(12, 1), 12, $urandom_range(100, 70),
               $urandom_range(7, 0), 1'($urandom_range(1, 0)));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule